// File: doc/BRIEF.md
# Programmable-Frame Serial Audio Receiver

This block turns a serial audio stream into parallel words. An external bit clock, a frame sync and a data line are brought into the system clock domain. Each of the three lines passes through a short synchronizer, and the chosen transition of the bit clock becomes a one-cycle sampling tick. A frame opens on a frame sync. After a programmable delay, bits are shifted in MSB first. Each finished word is written right-justified into a 32-bit holding register, together with a one-cycle ready strobe for a DMA engine or host.

A frame has one or two phases. Each phase has its own word length and word count. A single control word sets these, along with the data delay and the reaction to a frame sync that arrives while a frame is already running. Two sticky flags report an overrun of the holding register and an aborted frame. Both flags clear when the receiver is disabled.

Top module: `serial_audio_rx`

## Requirements
- R1: A word length code selects the number of bits per word: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32. The phase-1 code is in ctrl_i[7:5] and the phase-2 code in ctrl_i[23:21]. Bits arrive MSB first, and each word appears right-justified on data_o with the upper bits zero.
- R2: The number of words in a phase is programmed as count minus one, in ctrl_i[14:8] for phase 1 and ctrl_i[30:24] for phase 2. After the last word the receiver goes idle until the next frame sync.
- R3: When ctrl_i[31] is set, a frame holds the phase-1 words followed by the phase-2 words. When it is clear, a frame holds only phase-1 words.
- R4: ctrl_i[17:16] gives the number of bit-clock ticks between the frame-sync tick and the first data bit. A value of 0 makes the frame-sync tick carry the first data bit. A value of 1 or 2 skips that many ticks, whatever the data line carries during them. A value of 3 acts as 2.
- R5: With clk_pol_i=1, lines are sampled on rising transitions of sclk_i. With clk_pol_i=0, they are sampled on falling transitions.
- R6: With fs_pol_i=0, fsync_i is active high. With fs_pol_i=1, it is active low. A frame sync is a sampling tick at which the sync line is active after being inactive at the previous tick.
- R7: When ctrl_i[18] is set, a frame sync that arrives during a frame is ignored, the frame continues unchanged, and sync_err_o stays clear.
- R8: When ctrl_i[18] is clear, a frame sync that arrives during a frame discards the partial word and restarts framing from that sync. It also sets sync_err_o, which stays set until the receiver is disabled.
- R9: ready_o pulses for one clk_i cycle per completed word, with data_o holding that word. ready_o rises on the (SYNC_STAGES+1)-th rising clk_i edge after the sampling transition of the word's last bit reaches sclk_i. data_o holds its value until the next word.
- R10: If a word completes while the previous one has not been taken by rd_i, ovr_o sets and stays set, and the new word replaces the held one.
- R11: While en_i is low the receiver is idle and gives no strobes, and ovr_o and sync_err_o read 0. Lowering en_i discards a partial word, so the next frame sync after re-enabling starts a fresh frame.
- R12: Sampling ticks with no frame sync while idle produce no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low holds it idle and clears the flags |
| ctrl_i | input | 32 | Frame control word (fields in R1 to R4, R7, R8) |
| clk_pol_i | input | 1 | Bit clock sampling edge select |
| fs_pol_i | input | 1 | Frame sync polarity select |
| sclk_i | input | 1 | Receive bit clock |
| fsync_i | input | 1 | Receive frame sync |
| sdata_i | input | 1 | Serial data |
| rd_i | input | 1 | Read acknowledge for the held word |
| data_o | output | 32 | Holding register, right-justified word |
| ready_o | output | 1 | One-cycle strobe for a new word |
| ovr_o | output | 1 | Sticky overrun flag |
| sync_err_o | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
The bench uses the default SYNC_STAGES of 2, so every word must arrive exactly three system cycles after the sampling transition of its last bit. A strobe one cycle early or late counts as a failure. Each bit period is four system cycles, which keeps runs short. Even so, it covers every word length from 8 to 32 bits, all three data delays, both phase modes with unequal word counts, and both polarities of clock and frame sync. A single frame sync can be placed inside a word, which reaches both the ignore and the abort path. Turning off the automatic read produces an overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 32;
  localparam int BCNT_W = $clog2(DATA_W) + 1;
  localparam int WCNT_W = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_DATA} rx_state_e;

  typedef struct packed {
    logic              dual;
    logic [WCNT_W-1:0] wcnt2;
    logic [2:0]        wlen2;
    logic [1:0]        rsv_hi;
    logic              ign_fs;
    logic [1:0]        dly;
    logic              rsv_mid;
    logic [WCNT_W-1:0] wcnt1;
    logic [2:0]        wlen1;
    logic [4:0]        rsv_lo;
  } rx_ctrl_t;

  function automatic logic [BCNT_W-1:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return BCNT_W'(8);
      3'd1:    return BCNT_W'(12);
      3'd2:    return BCNT_W'(16);
      3'd3:    return BCNT_W'(20);
      3'd4:    return BCNT_W'(24);
      default: return BCNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/srx_edge.sv
module srx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  input  logic sclk_i,
  input  logic fsync_i,
  input  logic sdata_i,
  output logic tick_o,
  output logic fs_o,
  output logic bit_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_q, fs_q, dat_q;
  logic                   sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= '0;
      fs_q     <= '0;
      dat_q    <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      sclk_q   <= {sclk_q[MSB-1:0], sclk_i};
      fs_q     <= {fs_q[MSB-1:0], fsync_i};
      dat_q    <= {dat_q[MSB-1:0], sdata_i};
      sclk_d_q <= sclk_q[MSB];
    end
  end

  assign tick_o = clk_pol_i ? (sclk_q[MSB] & ~sclk_d_q) : (~sclk_q[MSB] & sclk_d_q);
  assign fs_o   = fs_q[MSB] ^ fs_pol_i;
  assign bit_o  = dat_q[MSB];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       ctrl_i,
  input  logic              tick_i,
  input  logic              fs_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              sync_err_o
);
  rx_ctrl_t          cfg;
  rx_state_e         state_q;
  logic              phase_q, fs_prev_q, serr_q;
  logic [1:0]        dly_q, dly_cfg;
  logic [BCNT_W-1:0] bit_q, base_bits, wlen;
  logic [WCNT_W-1:0] wcnt_q, wlast;
  logic [DATA_W-1:0] sh_q, base_sh, next_sh;
  logic              fs_new, in_frame, start, abort, shift_in, word_done;
  logic              unused_rsv;

  assign cfg        = rx_ctrl_t'(ctrl_i);
  assign unused_rsv = ^{cfg.rsv_hi, cfg.rsv_mid, cfg.rsv_lo};
  assign dly_cfg    = (cfg.dly == 2'd3) ? 2'd2 : cfg.dly;

  assign fs_new   = tick_i & fs_i & ~fs_prev_q;
  assign in_frame = (state_q != ST_IDLE);
  assign start    = fs_new & (~in_frame | ~cfg.ign_fs);
  assign abort    = fs_new & in_frame & ~cfg.ign_fs;

  assign wlen  = (start | ~phase_q) ? wlen_bits(cfg.wlen1) : wlen_bits(cfg.wlen2);
  assign wlast = phase_q ? cfg.wcnt2 : cfg.wcnt1;

  assign shift_in  = tick_i & (start ? (dly_cfg == 2'd0)
                                     : ((state_q == ST_DATA) |
                                        ((state_q == ST_DELAY) & (dly_q == 2'd0))));
  assign base_bits = (start | (state_q != ST_DATA)) ? '0 : bit_q;
  assign base_sh   = start ? '0 : sh_q;
  assign next_sh   = {base_sh[DATA_W-2:0], bit_i};
  assign word_done = shift_in & ((base_bits + 1'b1) == wlen);

  assign word_o     = next_sh;
  assign word_vld_o = en_i & word_done;
  assign sync_err_o = serr_q;

  // sync history runs on every tick so enabling mid-pulse sees no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fs_prev_q <= 1'b0;
    else if (tick_i) fs_prev_q <= fs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      dly_q   <= '0;
      bit_q   <= '0;
      wcnt_q  <= '0;
      sh_q    <= '0;
      serr_q  <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      bit_q   <= '0;
      wcnt_q  <= '0;
      sh_q    <= '0;
      serr_q  <= 1'b0;
    end else if (tick_i) begin
      if (start) begin
        phase_q <= 1'b0;
        wcnt_q  <= '0;
        if (abort) serr_q <= 1'b1;
        if (dly_cfg == 2'd0) begin
          state_q <= ST_DATA;
          sh_q    <= next_sh;
          bit_q   <= BCNT_W'(1);
        end else begin
          state_q <= ST_DELAY;
          dly_q   <= dly_cfg - 2'd1;
          sh_q    <= '0;
          bit_q   <= '0;
        end
      end else begin
        case (state_q)
          ST_DELAY: begin
            if (dly_q == 2'd0) begin
              state_q <= ST_DATA;
              sh_q    <= next_sh;
              bit_q   <= BCNT_W'(1);
            end else begin
              dly_q <= dly_q - 2'd1;
            end
          end
          ST_DATA: begin
            if (word_done) begin
              sh_q  <= '0;
              bit_q <= '0;
              if (wcnt_q == wlast) begin
                wcnt_q <= '0;
                if (!phase_q && cfg.dual) phase_q <= 1'b1;
                else                      state_q <= ST_IDLE;
              end else begin
                wcnt_q <= wcnt_q + 1'b1;
              end
            end else begin
              sh_q  <= next_sh;
              bit_q <= bit_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_word_in_frame_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (state_q == ST_DATA));

  assert_serr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o && en_i) |=> sync_err_o);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              vld_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o
);
  logic full_q, ovr_q, rdy_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= vld_i;
      if (vld_i) begin
        data_q <= word_i;
        full_q <= 1'b1;
        if (full_q && !rd_i) ovr_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign ready_o = rdy_q;
  assign ovr_o   = ovr_q;

  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_ovr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && en_i) |=> ovr_o);

  assert_quiet_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ready_o && !ovr_o));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       ctrl_i,
  input  logic              clk_pol_i,
  input  logic              fs_pol_i,
  input  logic              sclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              sync_err_o
);
  logic tick, fs_act, bit_s, word_vld;
  logic [DATA_W-1:0] word;

  srx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_pol_i (clk_pol_i),
    .fs_pol_i  (fs_pol_i),
    .sclk_i    (sclk_i),
    .fsync_i   (fsync_i),
    .sdata_i   (sdata_i),
    .tick_o    (tick),
    .fs_o      (fs_act),
    .bit_o     (bit_s)
  );

  srx_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ctrl_i     (ctrl_i),
    .tick_i     (tick),
    .fs_i       (fs_act),
    .bit_i      (bit_s),
    .word_o     (word),
    .word_vld_o (word_vld),
    .sync_err_o (sync_err_o)
  );

  srx_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .word_i  (word),
    .vld_i   (word_vld),
    .rd_i    (rd_i),
    .data_o  (data_o),
    .ready_o (ready_o),
    .ovr_o   (ovr_o)
  );
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int LAT = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic clk_pol_i = 1'b1, fs_pol_i = 1'b0;
  logic sclk_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic rd_i = 1'b0;
  logic [31:0] data_o;
  logic ready_o, ovr_o, sync_err_o;

  serial_audio_rx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ctrl_i(ctrl_i),
    .clk_pol_i(clk_pol_i), .fs_pol_i(fs_pol_i), .sclk_i(sclk_i),
    .fsync_i(fsync_i), .sdata_i(sdata_i), .rd_i(rd_i),
    .data_o(data_o), .ready_o(ready_o), .ovr_o(ovr_o), .sync_err_o(sync_err_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    int          t;
    logic [31:0] w;
    string       req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int last_edge = 0;
  logic cpol = 1'b1, fpol = 1'b0;
  bit auto_rd = 1'b1;
  int n_chk_m = 0, n_fail_m = 0;
  int n_chk_s = 0, n_fail_s = 0;
  int n_strobe = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // per-cycle comparison of the strobe against the expected word stream
  always @(negedge clk_i) begin
    if (ready_o) begin
      n_strobe = n_strobe + 1;
      n_chk_s = n_chk_s + 1;
      if (q.size() == 0) begin
        n_fail_s = n_fail_s + 1;
        $display("FAIL R12: unexpected strobe at cycle %0d, actual data %h expected no word", cyc, data_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (data_o !== e.w || cyc != e.t) begin
          n_fail_s = n_fail_s + 1;
          $display("FAIL %s/R9: actual %h at cycle %0d, expected %h at cycle %0d",
                   e.req, data_o, cyc, e.w, e.t);
        end
      end
    end else if (q.size() > 0 && cyc > q[0].t) begin
      exp_t e;
      e = q.pop_front();
      n_chk_s = n_chk_s + 1;
      n_fail_s = n_fail_s + 1;
      $display("FAIL %s/R9: no strobe, expected %h at cycle %0d", e.req, e.w, e.t);
    end
    rd_i = auto_rd && ready_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk_m = n_chk_m + 1;
    if (!ok) begin
      n_fail_m = n_fail_m + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic dual, input int wc2, input logic [2:0] wl2,
                                     input logic ign, input logic [1:0] dly,
                                     input int wc1, input logic [2:0] wl1);
    return {dual, 7'(wc2), wl2, 2'b00, ign, dly, 1'b0, 7'(wc1), wl1, 5'b0};
  endfunction

  task automatic setup(input logic [31:0] c, input logic cp, input logic fp);
    @(negedge clk_i);
    ctrl_i = c; clk_pol_i = cp; fs_pol_i = fp; cpol = cp; fpol = fp;
    sclk_i = ~cp; fsync_i = fp;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic slot(input logic fs, input logic sd);
    @(negedge clk_i);
    sclk_i = ~cpol; fsync_i = fs ^ fpol; sdata_i = sd;
    @(negedge clk_i);
    @(negedge clk_i);
    sclk_i = cpol; last_edge = cyc;
    @(negedge clk_i);
  endtask

  task automatic lead(input int d);
    if (d > 0) begin
      slot(1'b1, 1'b1);
      for (int i = 1; i < d; i++) slot(1'b0, 1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, 1'b1);
  endtask

  task automatic word(input logic [31:0] w, input int len, input int fs_at,
                      input bit exp_it, input string req);
    for (int i = len - 1; i >= 0; i--) slot(i == fs_at, w[i]);
    if (exp_it) begin
      exp_t e;
      e.t = last_edge + LAT;
      e.w = (len == 32) ? w : (w & ((32'h1 << len) - 1));
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic run_tests();
    int s0;
    repeat (3) @(negedge clk_i);
    chk(ready_o == 1'b0 && ovr_o == 1'b0 && sync_err_o == 1'b0, "R11 reset flags",
        {29'b0, ready_o, ovr_o, sync_err_o}, 32'h0);
    chk(data_o == 32'h0, "R9 reset data", data_o, 32'h0);
    en_i = 1'b1;

    // R2 single phase, two 16-bit words, delay 1, rising clock, active-high sync
    setup(mk(0, 0, 3'd0, 0, 2'd1, 1, 3'd2), 1'b1, 1'b0);
    lead(1);
    word(32'hA5C3, 16, -1, 1, "R2");
    word(32'h1234, 16, -1, 1, "R2");
    idle(3);
    chk(ovr_o == 0 && sync_err_o == 0, "R10 no flags after clean frame",
        {30'b0, ovr_o, sync_err_o}, 32'h0);

    // R3 dual phase: 1x8 then 2x24, delay 0
    setup(mk(1, 1, 3'd4, 0, 2'd0, 0, 3'd0), 1'b1, 1'b0);
    word(32'h96, 8, 7, 1, "R3");
    word(32'hABCDEF, 24, -1, 1, "R3");
    word(32'h135790, 24, -1, 1, "R3");
    idle(2);

    // R4 R5 R6 delay 2, falling clock, active-low sync, 2x12 then 1x20
    setup(mk(1, 0, 3'd3, 0, 2'd2, 1, 3'd1), 1'b0, 1'b1);
    lead(2);
    word(32'hA5F, 12, -1, 1, "R5");
    word(32'h3C1, 12, -1, 1, "R6");
    word(32'hF0E1D, 20, -1, 1, "R4");
    idle(2);

    // R1 32-bit word, delay code 3 behaves as 2
    setup(mk(0, 0, 3'd0, 0, 2'd3, 0, 3'd5), 1'b1, 1'b0);
    lead(2);
    word(32'hDEADBEEF, 32, -1, 1, "R1");
    idle(2);

    // R12 ticks without a frame sync give nothing
    s0 = n_strobe;
    idle(20);
    chk(n_strobe == s0, "R12 idle ticks", 32'(n_strobe - s0), 32'h0);

    // R7 mid-word sync ignored
    setup(mk(0, 0, 3'd0, 1, 2'd1, 1, 3'd2), 1'b1, 1'b0);
    lead(1);
    word(32'hBEEF, 16, 5, 1, "R7");
    word(32'h0F0F, 16, -1, 1, "R7");
    idle(2);
    chk(sync_err_o == 1'b0, "R7 no sync error", {31'b0, sync_err_o}, 32'h0);

    // R8 mid-word sync aborts and restarts
    setup(mk(0, 0, 3'd0, 0, 2'd1, 0, 3'd2), 1'b1, 1'b0);
    lead(1);
    word(32'h3F, 6, -1, 0, "R8");
    lead(1);
    word(32'h4321, 16, -1, 1, "R8");
    idle(2);
    chk(sync_err_o == 1'b1, "R8 sync error set", {31'b0, sync_err_o}, 32'h1);

    // R10 overrun without reads
    auto_rd = 1'b0;
    setup(mk(0, 0, 3'd0, 0, 2'd0, 1, 3'd0), 1'b1, 1'b0);
    word(32'h5A, 8, 7, 1, "R10");
    word(32'hC3, 8, -1, 1, "R10");
    idle(2);
    chk(ovr_o == 1'b1, "R10 overrun set", {31'b0, ovr_o}, 32'h1);
    chk(data_o == 32'hC3, "R10 newest word held", data_o, 32'hC3);
    chk(sync_err_o == 1'b1, "R8 sync error sticky", {31'b0, sync_err_o}, 32'h1);
    auto_rd = 1'b1;

    // R11 disable clears flags, blocks frames, discards partial word
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(ovr_o == 0 && sync_err_o == 0, "R11 flags cleared",
        {30'b0, ovr_o, sync_err_o}, 32'h0);
    setup(mk(0, 0, 3'd0, 1, 2'd1, 0, 3'd2), 1'b1, 1'b0);
    s0 = n_strobe;
    lead(1);
    word(32'hFFFF, 16, -1, 0, "R11");
    idle(2);
    chk(n_strobe == s0, "R11 no strobe while off", 32'(n_strobe - s0), 32'h0);
    @(negedge clk_i); en_i = 1'b1;
    lead(1);
    word(32'h1F, 5, -1, 0, "R11");
    @(negedge clk_i); en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    lead(1);
    word(32'h7E81, 16, -1, 1, "R11");
    idle(3);
    chk(sync_err_o == 1'b0, "R11 fresh frame after re-enable", {31'b0, sync_err_o}, 32'h0);

    repeat (10) @(negedge clk_i);
    chk(q.size() == 0, "R9 all words delivered", 32'(q.size()), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk_i);
        n_chk_m = n_chk_m + 1;
        n_fail_m = n_fail_m + 1;
        $display("FAIL R9: watchdog expired, actual running expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk_m + n_chk_s, n_fail_m + n_fail_s);
    $finish;
  end
endmodule